// File: doc/BRIEF.md
# Quasi-Cyclic Circulant Shift Network

This block sits between the variable-node and check-node processing arrays of a structured low-density parity-check decoder. Each transfer carries one sub-block's worth of messages: a vector of up to 96 lanes, each lane one message word. A shift code from the base model matrix comes with the vector. The block rotates the vector cyclically within the first Zf lanes. Zf is the expansion factor in use, and it can change from one transfer to the next.

A shift code of −1 stands for an all-zero sub-block and produces an all-zero vector. An inverse-direction input selects the opposite rotation, so the same network serves the return path toward the variable-node units. Results appear one clock after the accepted input. A fault flag marks an unusable expansion factor or an unusable shift code.

Top module: `qc_circulant_shift`

## Requirements
- R1: After reset, `valid_out` is 0, `err_out` is 0 and `data_out` is all zeros.
- R2: `valid_out` is high in the cycle after `valid_in` was high at a rising edge, and low in the cycle after `valid_in` was low.
- R3: With `inverse_in` = 0 and a legal transfer, output lane i (bits i*8 to i*8+7) for i < Zf equals input lane (i + s) mod Zf, where s is the non-negative shift code.
- R4: With `inverse_in` = 1, output lane i for i < Zf equals input lane (i − (s mod Zf)) mod Zf. A forward transfer followed by an inverse transfer with the same code and Zf returns the original vector.
- R5: Shift code −1 (all ones in `shift_in`) yields an all-zero output with `err_out` = 0.
- R6: Output lanes at index Zf and above are zero on every accepted transfer.
- R7: A Zf outside 24..96, or one that is not a multiple of 4, sets `err_out` to 1 and forces `data_out` to zero.
- R8: A negative shift code other than −1 sets `err_out` to 1 and forces `data_out` to zero.
- R9: While `valid_in` is low, `data_out` and `err_out` keep their values, whatever the other inputs do.
- R10: Shift codes of Zf or more wrap modulo Zf. For example, code 46 with Zf = 24 rotates by 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Transfer strobe |
| inverse_in | input | 1 | 1 selects the return-path (inverse) rotation |
| shift_in | input | 8 | Signed shift code from the base matrix; −1 marks an all-zero sub-block |
| zf_in | input | 7 | Expansion factor (active lane count) |
| data_in | input | 768 | 96 lanes of 8-bit messages, lane 0 in the low bits |
| valid_out | output | 1 | Result strobe, one cycle after `valid_in` |
| err_out | output | 1 | Illegal expansion factor or shift code on the last accepted transfer |
| data_out | output | 768 | Rotated and masked message vector |

## Verification
The bench targets these corner cases:
- **Rotation seam.** Codes next to and beyond Zf are applied. A design that wraps at the full lane width rather than at Zf pulls stale lanes in past index Zf−1.
- **Zero residue in inverse mode.** Codes whose residue is zero are run in inverse mode. A design that rotates by Zf there, without folding it to zero, reads lanes from outside the active window.
- **Illegal expansion factors.** Values just off a multiple of 4, and values just outside 24..96, must raise the flag and blank the output. A design with a loose range check forwards garbage instead.
- **Idle cycles.** The bench changes the data on idle cycles. A design that loads without `valid_in` shows the new data.
- **Round trip and random transfers.** A forward/inverse round trip and random transfers over all legal Zf values check that the lane mask holds.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
  parameter int LANE_MAX = 96;
  parameter int MSG_W    = 8;
  parameter int ZF_MIN   = 24;
  parameter int ZF_STEP  = 4;
  parameter int SHIFT_W  = 8;

  localparam int ZF_W   = $clog2(LANE_MAX + 1);
  localparam int ROT_W  = ZF_W;
  localparam int IDX_W  = $clog2(LANE_MAX);
  localparam int VEC_W  = LANE_MAX * MSG_W;
  localparam int REM_W  = ((SHIFT_W > ZF_W) ? SHIFT_W : ZF_W) + 1;
  localparam int SUB_STEPS = ((1 << (SHIFT_W - 1)) - 1) / ZF_MIN + 1;

  typedef struct packed {
    logic             load;
    logic             blank;
    logic             fault;
    logic [ROT_W-1:0] rot;
    logic [ZF_W-1:0]  zf;
  } qcsStrobe_t;
endpackage

// File: rtl/qcs_ctrl.sv
module qcs_ctrl
  import qcs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      loadIn,
  input  logic                      invIn,
  input  logic signed [SHIFT_W-1:0] shiftIn,
  input  logic [ZF_W-1:0]           zfIn,
  output qcsStrobe_t                strobe
);
  logic             zfOk;
  logic             skipBlk;
  logic             badShift;
  logic [REM_W-1:0] residue;
  logic [ROT_W-1:0] fwdRot;
  logic [ROT_W-1:0] invRot;

  always_comb begin
    zfOk = (zfIn >= ZF_W'(ZF_MIN)) && (zfIn <= ZF_W'(LANE_MAX)) &&
           ((zfIn % ZF_W'(ZF_STEP)) == '0);
    skipBlk  = (shiftIn == '1);
    badShift = shiftIn[SHIFT_W-1] && !skipBlk;
  end

  // shift code modulo Zf by repeated conditional subtraction
  always_comb begin
    residue = REM_W'(shiftIn[SHIFT_W-2:0]);
    for (int k = 0; k < SUB_STEPS; k++) begin
      if (residue >= REM_W'(zfIn)) residue = residue - REM_W'(zfIn);
    end
    fwdRot = ROT_W'(residue);
    invRot = (fwdRot == '0) ? '0 : (zfIn - fwdRot);
  end

  always_comb begin
    strobe.load  = loadIn;
    strobe.fault = !zfOk || badShift;
    strobe.blank = !zfOk || badShift || skipBlk;
    strobe.rot   = invIn ? invRot : fwdRot;
    strobe.zf    = zfIn;
  end

  // R3 / R10: the reduced rotation always lies inside the active window
  a_r10_rot_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && !strobe.blank) |-> (strobe.rot < strobe.zf));
endmodule

// File: rtl/qcs_datapath.sv
module qcs_datapath
  import qcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  qcsStrobe_t       strobe,
  input  logic [VEC_W-1:0] dataIn,
  output logic [VEC_W-1:0] dataOut,
  output logic             faultOut
);
  logic [MSG_W-1:0] laneIn [LANE_MAX];
  logic [VEC_W-1:0] rotated;
  logic [VEC_W-1:0] deadMask;

  for (genvar g = 0; g < LANE_MAX; g++) begin : g_lane
    logic [ZF_W:0] srcPos;
    logic          laneLive;

    assign laneIn[g] = dataIn[g*MSG_W +: MSG_W];

    always_comb begin
      laneLive = ((ZF_W+1)'(g) < {1'b0, strobe.zf});
      srcPos   = (ZF_W+1)'(g) + {1'b0, strobe.rot};
      if (srcPos >= {1'b0, strobe.zf}) srcPos = srcPos - {1'b0, strobe.zf};
      if (laneLive && !strobe.blank && (srcPos < (ZF_W+1)'(LANE_MAX)))
        rotated[g*MSG_W +: MSG_W] = laneIn[IDX_W'(srcPos)];
      else
        rotated[g*MSG_W +: MSG_W] = '0;
      deadMask[g*MSG_W +: MSG_W] = laneLive ? '0 : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataOut  <= '0;
      faultOut <= 1'b0;
    end else if (strobe.load) begin
      dataOut  <= rotated;
      faultOut <= strobe.fault;
    end
  end

  a_r7_fault_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    faultOut |-> (dataOut == '0));
  a_r5_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.blank) |=> (dataOut == '0));
  a_r6_dead_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> ((dataOut & $past(deadMask)) == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(dataOut) && $stable(faultOut)));
endmodule

// File: rtl/qc_circulant_shift.sv
module qc_circulant_shift
  import qcs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid_in,
  input  logic                      inverse_in,
  input  logic signed [SHIFT_W-1:0] shift_in,
  input  logic [ZF_W-1:0]           zf_in,
  input  logic [VEC_W-1:0]          data_in,
  output logic                      valid_out,
  output logic                      err_out,
  output logic [VEC_W-1:0]          data_out
);
  qcsStrobe_t strobe;

  qcs_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .loadIn  (valid_in),
    .invIn   (inverse_in),
    .shiftIn (shift_in),
    .zfIn    (zf_in),
    .strobe  (strobe)
  );

  qcs_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .dataIn   (data_in),
    .dataOut  (data_out),
    .faultOut (err_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) valid_out <= 1'b0;
    else        valid_out <= valid_in;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
endmodule

// File: tb/qc_circulant_shift_test.sv
`timescale 1ns/1ps
module qc_circulant_shift_test;
  localparam int LN  = 96;
  localparam int MW  = 8;
  localparam int TOT = LN * MW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_in = 1'b0;
  logic            inverse_in = 1'b0;
  logic [7:0]      shift_in = '0;
  logic [6:0]      zf_in = 7'd24;
  logic [TOT-1:0]  data_in = '0;
  logic            valid_out;
  logic            err_out;
  logic [TOT-1:0]  data_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  qc_circulant_shift uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .inverse_in(inverse_in),
    .shift_in(shift_in), .zf_in(zf_in), .data_in(data_in),
    .valid_out(valid_out), .err_out(err_out), .data_out(data_out)
  );

  function automatic bit zfLegal(input int zf);
    return (zf >= 24) && (zf <= 96) && (zf % 4 == 0);
  endfunction

  function automatic bit expErr(input int zf, input int sh);
    return !zfLegal(zf) || (sh < -1);
  endfunction

  function automatic logic [TOT-1:0] model(input logic [TOT-1:0] d, input int zf,
                                           input int sh, input bit inv);
    logic [TOT-1:0] r = '0;
    int s;
    if (expErr(zf, sh) || sh == -1) return r;
    s = sh % zf;
    if (inv) s = (zf - s) % zf;
    for (int i = 0; i < zf; i++) r[i*MW +: MW] = d[((i + s) % zf)*MW +: MW];
    return r;
  endfunction

  function automatic logic [TOT-1:0] randVec();
    logic [TOT-1:0] v;
    for (int k = 0; k < TOT/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic checkVec(input string req, input logic [TOT-1:0] got, input logic [TOT-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s data actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic checkBit(input string req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic xfer(input bit inv, input int sh, input int zf,
                      input logic [TOT-1:0] d, input string req);
    @(negedge clk);
    valid_in = 1'b1; inverse_in = inv; shift_in = 8'(sh); zf_in = 7'(zf); data_in = d;
    @(negedge clk);
    checkBit({req, " R2"}, "valid_out", valid_out, 1'b1);
    checkBit(req, "err_out", err_out, expErr(zf, sh));
    checkVec(req, data_out, model(d, zf, sh, inv));
    valid_in = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TOT-1:0] v;
    logic [TOT-1:0] held;
    logic [TOT-1:0] fwd;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1 reset state
    checkBit("R1", "valid_out", valid_out, 1'b0);
    checkBit("R1", "err_out", err_out, 1'b0);
    checkVec("R1", data_out, '0);
    rst_n = 1'b1;

    v = randVec();
    xfer(1'b0, 0, 24, v, "R3 R6 identity");
    xfer(1'b0, 5, 96, v, "R3 full width");
    xfer(1'b0, 23, 24, v, "R3 seam");
    xfer(1'b0, 46, 24, v, "R10 wrap");
    xfer(1'b0, 40, 28, v, "R10 wrap 28");
    xfer(1'b1, 7, 48, v, "R4 inverse");
    xfer(1'b1, 24, 24, v, "R4 zero residue");
    xfer(1'b1, 0, 96, v, "R4 inverse zero");
    xfer(1'b0, -1, 64, v, "R5 skip");
    xfer(1'b0, 3, 25, v, "R7 zf not step");
    xfer(1'b0, 3, 100, v, "R7 zf high");
    xfer(1'b0, 3, 20, v, "R7 zf low");
    xfer(1'b0, -5, 48, v, "R8 negative");
    xfer(1'b0, -128, 48, v, "R8 most negative");

    // R4 round trip
    v = randVec();
    xfer(1'b0, 33, 72, v, "R4 fwd leg");
    fwd = data_out;
    xfer(1'b1, 33, 72, fwd, "R4 inv leg");
    checkVec("R4 roundtrip", data_out, model(v, 72, 0, 1'b0));

    // R9 hold: idle cycle with different inputs
    xfer(1'b0, 9, 40, v, "R9 setup");
    held = data_out;
    @(negedge clk);
    valid_in = 1'b0; shift_in = 8'd1; zf_in = 7'd99; data_in = randVec();
    @(negedge clk);
    checkBit("R9 R2", "valid_out", valid_out, 1'b0);
    checkBit("R9", "err_out", err_out, 1'b0);
    checkVec("R9", data_out, held);

    // random transfers across legal and illegal settings
    for (int n = 0; n < 400; n++) begin
      int zf;
      int sh;
      bit inv;
      zf  = 24 + 4 * int'($urandom % 19);
      if ($urandom % 16 == 0) zf = int'($urandom % 128);
      sh  = int'($urandom % 48) - 1;
      if ($urandom % 8 == 0) sh = int'($urandom % 256) - 128;
      inv = 1'($urandom);
      xfer(inv, sh, zf, randVec(), "R3 R4 R6 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule